// File: doc/BRIEF.md
# Infrared Pulse Run-Length Encoder

This block takes the output of a demodulating infrared receiver and describes it as a list of runs. The raw line is brought into the clock domain and sampled once per sample tick. The tick comes from the module clock through a fixed divider. Every run of equal level becomes one byte: the top bit gives the level and the low seven bits give the run length. A glitch filter absorbs short spikes. A long quiet gap closes the packet with a one-cycle packet-end strobe. A downstream FIFO or decoder takes each byte on the cycle its valid strobe is high.

The run tracker is a three-state machine. `ST_WAIT` ignores the line until an accepted pulse level arrives; that transition is named *start*. `ST_PULSE` counts a pulse run. It moves to `ST_SPACE` on *pulse_end*, which emits the pulse symbol. `ST_SPACE` counts a space run. It returns to `ST_PULSE` on *space_end*, which emits the space symbol. It falls back to `ST_WAIT` on *idle_hit*, which emits the last space symbol together with the packet-end strobe. In `ST_PULSE` and `ST_SPACE`, a run that reaches 128 samples stays in the same state (*split*) and emits a full-length symbol. Whenever either enable is low, the machine is forced to `ST_WAIT`.

The thresholds, the polarity bit and the two enables are static configuration. They are changed only while capture is disabled.

Top module: `ir_rle_encoder`

## Requirements
- R1: The sample tick occurs once every DIV module clocks (default 64). Only the level seen at a tick contributes to a run, and each tick adds exactly one sample to the current run.
- R2: Symbol byte encoding: bit 7 is the run level (1 = pulse, 0 = space). Bits 6:0 hold the run length minus one, so value N means N+1 samples.
- R3: When `invert` is 1, the synchronized input is complemented before filtering. An active-low receiver then yields the same symbols as an active-high one.
- R4: A new level is accepted only after it has been seen on max(`noise_thr`,1) consecutive ticks. Shorter excursions are absorbed into the surrounding run, and accepted runs keep their true length. A run exactly that long is accepted.
- R5: Let T be `idle_thr`, with T ≥ 1. When a space run reaches T+1 samples, the block emits the remaining space symbol(s), totalling T samples, and raises `pkt_end` for one cycle together with the last symbol. A space of exactly T samples does not end the packet.
- R6: A run longer than 128 samples is split. A symbol with length field 0x7F and the same level is emitted each time 128 samples have accumulated, and counting then continues.
- R7: After the packet-end strobe, no symbol is emitted until an accepted transition to the pulse level. The space that follows produces no output.
- R8: No symbol and no packet-end strobe appear while `glb_en` or `rx_en` is low.
- R9: Dropping an enable synchronously clears the run counter, the filter state and the divider. A later packet is encoded as if capture had just started.
- R10: The raw input passes through two flops before sampling. A change made at least three clocks before a tick is counted at that tick.
- R11: While reset is asserted, `sym_valid`, `pkt_end` and `sym_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| invert | input | 1 | Complement the input polarity |
| noise_thr | input | 6 | Samples a new level must persist before it is accepted |
| idle_thr | input | 8 | Space length in samples beyond which the packet ends |
| ir_in | input | 1 | Raw demodulated receiver line (asynchronous) |
| sym_data | output | 8 | Run symbol: level in bit 7, length minus one in bits 6:0 |
| sym_valid | output | 1 | One-cycle strobe marking `sym_data` valid |
| pkt_end | output | 1 | One-cycle strobe for packet end |

## Verification
An input edge reaches the sampler after two clocks. It is seen at the next tick, which comes once every 64 clocks after enable. The filter accepts the new level max(`noise_thr`,1) ticks later, and the symbol for the run that just ended appears two clocks after that tick: one clock through the filter register and one through the output register. The bench therefore changes the line only at fixed clock offsets after enable, inside the safe window of each sample period, and holds every level for whole periods. That makes each run length an exact number of ticks. The bench collects the strobes at the falling edge and compares the whole ordered symbol and packet-end sequence only after an idle tail longer than the filter delay plus the idle threshold. One case changes the line at offset 61, three clocks before the tick, to test the two-flop window boundary.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
    localparam int SYM_W  = 8;
    localparam int LEN_W  = SYM_W - 1;
    localparam logic [LEN_W-1:0] LEN_FULL = '1;

    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_PULSE = 2'd1,
        ST_SPACE = 2'd2
    } run_state_t;
endpackage

// File: rtl/ir_tick_gen.sv
// Two-flop synchronizer, polarity select and sample-tick divider.
module ir_tick_gen #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic invert,
    input  logic ir_raw,
    output logic smp_lvl,
    output logic smp_tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic meta_q, sync_q;
    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= ir_raw;
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + CW'(1);
        end
    end

    assign smp_lvl  = sync_q ^ invert;
    assign smp_tick = active && (div_q == LAST);
endmodule

// File: rtl/ir_glitch_filter.sv
// Accepts a new level only after it has persisted for the noise threshold.
module ir_glitch_filter #(
    parameter int NTHR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              smp_tick,
    input  logic              smp_lvl,
    input  logic [NTHR_W-1:0] noise_thr,
    output logic              flt_tick,
    output logic              flt_lvl
);
    logic              acc_q;
    logic [NTHR_W-1:0] pend_q;
    logic [NTHR_W-1:0] need;
    logic [NTHR_W:0]   pend_nx;

    assign need    = (noise_thr == '0) ? NTHR_W'(1) : noise_thr;
    assign pend_nx = {1'b0, pend_q} + (NTHR_W+1)'(1);

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            acc_q    <= 1'b0;
            pend_q   <= '0;
            flt_tick <= 1'b0;
        end else begin
            flt_tick <= smp_tick;
            if (smp_tick) begin
                if (smp_lvl == acc_q) begin
                    pend_q <= '0;
                end else if (pend_nx >= {1'b0, need}) begin
                    acc_q  <= smp_lvl;
                    pend_q <= '0;
                end else begin
                    pend_q <= pend_nx[NTHR_W-1:0];
                end
            end
        end
    end

    assign flt_lvl = acc_q;

    // R9: a dropped enable leaves the filter cleared on the next cycle
    assert_filter_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!flt_lvl && !flt_tick));

    // R4: the accepted level moves only as the result of a sample tick
    assert_level_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_lvl) |-> ($past(smp_tick) || !$past(active)));
endmodule

// File: rtl/ir_run_encoder.sv
// Run tracker: turns the filtered level stream into run symbols.
module ir_run_encoder
    import ir_rle_pkg::*;
#(
    parameter int ITHR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              flt_tick,
    input  logic              flt_lvl,
    input  logic [ITHR_W-1:0] idle_thr,
    output logic [SYM_W-1:0]  sym_data,
    output logic              sym_valid,
    output logic              pkt_end
);
    run_state_t        state_q, state_nx;
    logic [LEN_W-1:0]  seg_q;
    logic [ITHR_W:0]   idle_q;
    logic              idle_hit;
    logic              seg_full;

    assign idle_hit = (idle_q >= {1'b0, idle_thr});
    assign seg_full = (seg_q == LEN_FULL);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions: start, pulse_end, space_end, idle_hit, split (self)
    always_comb begin
        state_nx = state_q;
        if (flt_tick) begin
            unique case (state_q)
                ST_WAIT:  if (flt_lvl) state_nx = ST_PULSE;
                ST_PULSE: if (!flt_lvl) state_nx = ST_SPACE;
                ST_SPACE: begin
                    if (flt_lvl) begin
                        state_nx = ST_PULSE;
                    end else if (idle_hit) begin
                        state_nx = ST_WAIT;
                    end
                end
                default:  state_nx = ST_WAIT;
            endcase
        end
    end

    // outputs and run counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_data  <= '0;
            sym_valid <= 1'b0;
            pkt_end   <= 1'b0;
            seg_q     <= '0;
            idle_q    <= '0;
        end else if (!active) begin
            sym_valid <= 1'b0;
            pkt_end   <= 1'b0;
            seg_q     <= '0;
            idle_q    <= '0;
        end else begin
            sym_valid <= 1'b0;
            pkt_end   <= 1'b0;
            if (flt_tick) begin
                unique case (state_q)
                    ST_WAIT: begin
                        seg_q <= '0;
                    end
                    ST_PULSE: begin
                        if (!flt_lvl) begin
                            sym_data  <= {1'b1, seg_q};
                            sym_valid <= 1'b1;
                            seg_q     <= '0;
                            idle_q    <= (ITHR_W+1)'(1);
                        end else if (seg_full) begin
                            sym_data  <= {1'b1, LEN_FULL};
                            sym_valid <= 1'b1;
                            seg_q     <= '0;
                        end else begin
                            seg_q <= seg_q + LEN_W'(1);
                        end
                    end
                    ST_SPACE: begin
                        if (flt_lvl) begin
                            sym_data  <= {1'b0, seg_q};
                            sym_valid <= 1'b1;
                            seg_q     <= '0;
                        end else if (idle_hit) begin
                            sym_data  <= {1'b0, seg_q};
                            sym_valid <= 1'b1;
                            pkt_end   <= 1'b1;
                            seg_q     <= '0;
                        end else if (seg_full) begin
                            sym_data  <= {1'b0, LEN_FULL};
                            sym_valid <= 1'b1;
                            seg_q     <= '0;
                            idle_q    <= idle_q + (ITHR_W+1)'(1);
                        end else begin
                            seg_q  <= seg_q + LEN_W'(1);
                            idle_q <= idle_q + (ITHR_W+1)'(1);
                        end
                    end
                    default: seg_q <= '0;
                endcase
            end
        end
    end

    // R5: the packet-end strobe rides on a space symbol
    assert_pkt_with_space_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> (sym_valid && !sym_data[SYM_W-1]));

    // R1: symbols are produced only by a filtered sample tick
    assert_emit_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> $past(flt_tick));

    // R7: nothing follows the packet-end strobe directly
    assert_quiet_after_pkt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !sym_valid);

    // R8: no output when capture was disabled
    assert_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> $past(active));
endmodule

// File: rtl/ir_rle_encoder.sv
module ir_rle_encoder #(
    parameter int DIV    = 64,
    parameter int NTHR_W = 6,
    parameter int ITHR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              rx_en,
    input  logic              invert,
    input  logic [NTHR_W-1:0] noise_thr,
    input  logic [ITHR_W-1:0] idle_thr,
    input  logic              ir_in,
    output logic [7:0]        sym_data,
    output logic              sym_valid,
    output logic              pkt_end
);
    logic active;
    logic smp_lvl, smp_tick;
    logic flt_lvl, flt_tick;

    assign active = glb_en && rx_en;

    ir_tick_gen #(.DIV(DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .invert   (invert),
        .ir_raw   (ir_in),
        .smp_lvl  (smp_lvl),
        .smp_tick (smp_tick)
    );

    ir_glitch_filter #(.NTHR_W(NTHR_W)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .smp_tick  (smp_tick),
        .smp_lvl   (smp_lvl),
        .noise_thr (noise_thr),
        .flt_tick  (flt_tick),
        .flt_lvl   (flt_lvl)
    );

    ir_run_encoder #(.ITHR_W(ITHR_W)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .flt_tick  (flt_tick),
        .flt_lvl   (flt_lvl),
        .idle_thr  (idle_thr),
        .sym_data  (sym_data),
        .sym_valid (sym_valid),
        .pkt_end   (pkt_end)
    );
endmodule

// File: tb/tb_ir_rle_encoder.sv
module tb_ir_rle_encoder;
    localparam int PER = 64;
    localparam int PKT = 256;

    logic       clk = 1'b0;
    logic       rst_n, glb_en, rx_en, invert, ir_in;
    logic [5:0] noise_thr;
    logic [7:0] idle_thr;
    logic [7:0] sym_data;
    logic       sym_valid, pkt_end;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic inv_cfg = 1'b0;

    int exp_q [0:511];
    int got_q [0:511];
    int exp_n = 0;
    int got_n = 0;

    always #5 clk = ~clk;

    ir_rle_encoder dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rx_en(rx_en),
        .invert(invert), .noise_thr(noise_thr), .idle_thr(idle_thr),
        .ir_in(ir_in), .sym_data(sym_data), .sym_valid(sym_valid),
        .pkt_end(pkt_end)
    );

    // collector, sampled away from the rising edge
    always @(negedge clk) begin
        if (rst_n && got_n < 510) begin
            if (sym_valid) begin
                got_q[got_n] = int'(sym_data);
                got_n = got_n + 1;
            end
            if (pkt_end) begin
                got_q[got_n] = PKT;
                got_n = got_n + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input int v);
        exp_q[exp_n] = v;
        exp_n++;
    endtask

    // expected symbols for a run of len samples (R2 encoding, R6 split)
    task automatic push_run(input int lvl, input int len);
        int rem = len;
        while (rem > 128) begin
            push(lvl * 128 + 127);
            rem -= 128;
        end
        push(lvl * 128 + rem - 1);
    endtask

    task automatic hold(input logic lvl, input int n);
        ir_in = lvl ^ inv_cfg;
        repeat (n * PER) @(negedge clk);
    endtask

    task automatic start_test(input int nthr, input int ithr, input logic inv, input int offs);
        @(negedge clk);
        rx_en     = 1'b0;
        glb_en    = 1'b1;
        noise_thr = 6'(nthr);
        idle_thr  = 8'(ithr);
        invert    = inv;
        inv_cfg   = inv;
        ir_in     = inv;
        repeat (4) @(negedge clk);
        got_n = 0;
        exp_n = 0;
        rx_en = 1'b1;
        repeat (offs) @(negedge clk);
    endtask

    task automatic compare(input string req);
        check({req, " count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(req, got_q[i], exp_q[i]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; glb_en = 1'b1; rx_en = 1'b1; invert = 1'b0;
        noise_thr = 6'd1; idle_thr = 8'd20; ir_in = 1'b0;
        repeat (5) @(negedge clk);
        // R11: reset state
        check("R11 sym_valid", int'(sym_valid), 0);
        check("R11 pkt_end", int'(pkt_end), 0);
        check("R11 sym_data", int'(sym_data), 0);
        rst_n = 1'b1;

        // R1 R2 R5 R7: threshold 0 acts as 1, single-sample runs, space of exactly T
        start_test(0, 20, 1'b0, 10);
        hold(1, 9); hold(0, 4); hold(1, 1); hold(0, 1); hold(1, 3);
        hold(0, 20); hold(1, 12); hold(0, 25 + 150); hold(1, 5); hold(0, 25);
        push_run(1, 9); push_run(0, 4); push_run(1, 1); push_run(0, 1);
        push_run(1, 3); push_run(0, 20); push_run(1, 12); push_run(0, 20); push(PKT);
        push_run(1, 5); push_run(0, 20); push(PKT);
        compare("R1/R2/R5/R7");

        // R6: long runs split at 128, idle of 200 split too
        start_test(1, 200, 1'b0, 30);
        hold(1, 300); hold(0, 50); hold(1, 128); hold(0, 210);
        push_run(1, 300); push_run(0, 50); push_run(1, 128); push_run(0, 200); push(PKT);
        compare("R6/R5");

        // R4: glitches shorter than 3 samples absorbed; a 3-sample run kept
        start_test(3, 20, 1'b0, 10);
        hold(1, 8); hold(0, 2); hold(1, 6); hold(0, 3); hold(1, 1); hold(0, 3);
        hold(1, 5); hold(0, 4); hold(1, 3); hold(0, 28);
        push_run(1, 16); push_run(0, 7); push_run(1, 5); push_run(0, 4);
        push_run(1, 3); push_run(0, 20); push(PKT);
        compare("R4");

        // R3 R10: inverted receiver, edges three clocks before the tick
        start_test(2, 30, 1'b1, 61);
        hold(1, 6); hold(0, 3); hold(1, 2); hold(0, 2); hold(1, 20); hold(0, 36);
        push_run(1, 6); push_run(0, 3); push_run(1, 2); push_run(0, 2);
        push_run(1, 20); push_run(0, 30); push(PKT);
        compare("R3/R10");

        // R8: either enable low blocks all output
        start_test(1, 20, 1'b0, 10);
        glb_en = 1'b0;
        hold(1, 10); hold(0, 5); hold(1, 4); hold(0, 30);
        check("R8 glb_en low", got_n, 0);
        glb_en = 1'b1; rx_en = 1'b0;
        hold(1, 10); hold(0, 5); hold(1, 4); hold(0, 30);
        check("R8 rx_en low", got_n, 0);

        // R9: disable in mid-pulse, then a clean packet
        start_test(1, 20, 1'b0, 10);
        hold(1, 50);
        rx_en = 1'b0;
        hold(1, 5);
        ir_in = 1'b0;
        repeat (8) @(negedge clk);
        check("R9 no output", got_n, 0);
        rx_en = 1'b1;
        repeat (10) @(negedge clk);
        hold(1, 7); hold(0, 3); hold(1, 4); hold(0, 25);
        push_run(1, 7); push_run(0, 3); push_run(1, 4); push_run(0, 20); push(PKT);
        compare("R9");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule